// File: doc/BRIEF.md
# ADC Buffer-Full Flag Controller

This block sits between six ADC sample channels and two CPU ports. The channels are grouped in three pairs. When a pair's latch strobe is pulsed, both of its 16-bit output registers capture new samples and both of its buffer-full flags go high on the same clock edge. Each pair has one interrupt enable. The pair raises an interrupt request while either of its flags is set, provided that enable and a global interrupt-enable input are both high.

Each CPU port selects a channel and sees that channel's output register. A read strobe on either port clears only the flag of the selected channel. The control word puts the six flags in bits 0 to 5 and the three pair enables in bits 6 to 8. The first port can write the enable bits, and writes to the flag bits have no effect. The second port has no write path. The converter itself is outside the block.

Top module: `adc_flag_ctl`

## Requirements
- R1: After reset, ctrl_o, irq_o and all six output registers are zero.
- R2: A pulse on load_i[p] sets the flags of channels 2p and 2p+1 together on that clock edge. Flag c is ctrl_o bit c.
- R3: On the same edge, channel c's output register takes sample_i[16c +: 16]. A port data output shows the register of the channel that port selects.
- R4: A read strobe on port A for channel c clears flag c only, on that clock edge.
- R5: A read strobe on port B for channel c clears flag c only, on that clock edge. Reads on both ports in one cycle each clear their own channel.
- R6: When a load and a clearing read hit the same channel in one cycle, the flag ends up set.
- R7: irq_o[p] is high exactly when flag 2p or flag 2p+1 is set, ctrl_o bit 6+p is 1, and gie_i is 1.
- R8: A control write loads the pair enables from ctrl_wdata_i[8:6] on that edge. Written values in bits 0 to 5 are ignored. Bits 9 to 15 of ctrl_o always read 0.
- R9: A channel index of 6 or 7 on a port gives data 0, and a read strobe with that index clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 3 | Per-pair sample latch strobe |
| sample_i | input | 96 | Six 16-bit samples, channel c at bits 16c+15:16c |
| rd_a_i | input | 1 | Port A read strobe |
| rd_a_ch_i | input | 3 | Port A channel select |
| rd_a_data_o | output | 16 | Port A selected output register |
| rd_b_i | input | 1 | Port B read strobe |
| rd_b_ch_i | input | 3 | Port B channel select |
| rd_b_data_o | output | 16 | Port B selected output register |
| ctrl_wr_i | input | 1 | Control word write strobe (port A only) |
| ctrl_wdata_i | input | 16 | Control write data |
| gie_i | input | 1 | Global interrupt enable |
| ctrl_o | output | 16 | Control word: flags [5:0], pair enables [8:6] |
| irq_o | output | 3 | Per-pair interrupt request |

## Verification
A flag stuck high, cleared on the wrong channel, or losing to a simultaneous read shows up in ctrl_o one cycle after the stimulus. It also reaches irq_o in that cycle once the pair is enabled and gie_i is high. A register loaded from the wrong lane, or not loaded at all, shows on the data output of whichever port selects it, at the first sample after the load edge. The bench compares every output against a behavioural model on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
  parameter int unsigned NUM_PAIRS = 3;
  parameter int unsigned DATA_W    = 16;
  parameter int unsigned CTRL_W    = 16;
  parameter int unsigned EN_LSB    = 6;
  localparam int unsigned NUM_CH   = 2 * NUM_PAIRS;
  localparam int unsigned CH_W     = $clog2(NUM_CH);
endpackage

// File: rtl/adc_pair_slice.sv
module adc_pair_slice #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [2*DATA_W-1:0]   sample_i,
  input  logic [1:0]            clr_i,
  output logic [1:0]            flag_o,
  output logic [2*DATA_W-1:0]   data_o
);
  for (genvar k = 0; k < 2; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[k] <= 1'b0;
        data_o[k*DATA_W +: DATA_W] <= '0;
      end else if (load_i) begin
        flag_o[k] <= 1'b1;  // set wins over clear
        data_o[k*DATA_W +: DATA_W] <= sample_i[k*DATA_W +: DATA_W];
      end else if (clr_i[k]) begin
        flag_o[k] <= 1'b0;
      end
    end

    // R4 R5
    clr_drops_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] && !load_i |=> !flag_o[k]);
    // R2
    no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i && !flag_o[k] |=> !flag_o[k]);
  end

  // R2 R6
  pair_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> flag_o == 2'b11);
  // R3
  sample_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> data_o == $past(sample_i));
endmodule

// File: rtl/adc_rd_mux.sv
module adc_rd_mux #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CH_W   = 3
) (
  input  logic [CH_W-1:0]          ch_i,
  input  logic [NUM_CH*DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]        data_o
);
  always_comb begin
    data_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (ch_i == CH_W'(c)) data_o = regs_i[c*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/adc_flag_ctl.sv
module adc_flag_ctl
  import adc_flag_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_PAIRS-1:0]     load_i,
  input  logic [NUM_CH*DATA_W-1:0] sample_i,
  input  logic                     rd_a_i,
  input  logic [CH_W-1:0]          rd_a_ch_i,
  output logic [DATA_W-1:0]        rd_a_data_o,
  input  logic                     rd_b_i,
  input  logic [CH_W-1:0]          rd_b_ch_i,
  output logic [DATA_W-1:0]        rd_b_data_o,
  input  logic                     ctrl_wr_i,
  input  logic [CTRL_W-1:0]        ctrl_wdata_i,
  input  logic                     gie_i,
  output logic [CTRL_W-1:0]        ctrl_o,
  output logic [NUM_PAIRS-1:0]     irq_o
);
  logic [NUM_CH-1:0]        flags;
  logic [NUM_CH-1:0]        clr;
  logic [NUM_PAIRS-1:0]     en_q;
  logic [NUM_CH*DATA_W-1:0] regs;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
    assign clr[c] = (rd_a_i && rd_a_ch_i == CH_W'(c)) ||
                    (rd_b_i && rd_b_ch_i == CH_W'(c));
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    adc_pair_slice #(.DATA_W(DATA_W)) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i[p]),
      .sample_i (sample_i[2*p*DATA_W +: 2*DATA_W]),
      .clr_i    (clr[2*p +: 2]),
      .flag_o   (flags[2*p +: 2]),
      .data_o   (regs[2*p*DATA_W +: 2*DATA_W])
    );
    assign irq_o[p] = gie_i && en_q[p] && (flags[2*p] || flags[2*p+1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (ctrl_wr_i) en_q <= ctrl_wdata_i[EN_LSB +: NUM_PAIRS];
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[NUM_CH-1:0] = flags;
    ctrl_o[EN_LSB +: NUM_PAIRS] = en_q;
  end

  adc_rd_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_mux_a (
    .ch_i(rd_a_ch_i), .regs_i(regs), .data_o(rd_a_data_o));
  adc_rd_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_mux_b (
    .ch_i(rd_b_ch_i), .regs_i(regs), .data_o(rd_b_data_o));

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> irq_o == '0);
  // R8
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> ctrl_o[EN_LSB +: NUM_PAIRS] == $past(ctrl_wdata_i[EN_LSB +: NUM_PAIRS]));
  // R8
  wr_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && load_i == '0 && !rd_a_i && !rd_b_i |=> $stable(ctrl_o[NUM_CH-1:0]));
  // R9
  bad_ch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_i && rd_a_ch_i >= CH_W'(NUM_CH) && !rd_b_i && load_i == '0
    |=> $stable(ctrl_o[NUM_CH-1:0]));
endmodule

// File: tb/adc_flag_ctl_test.sv
module adc_flag_ctl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  load = '0;
  logic [95:0] sample = '0;
  logic        rd_a = 0, rd_b = 0;
  logic [2:0]  ch_a = '0, ch_b = '0;
  logic        wr = 0;
  logic [15:0] wdata = '0;
  logic        gie = 0;
  logic [15:0] da, db, ctrl;
  logic [2:0]  irq;

  int errors = 0, checks = 0, cycles = 0;
  logic [15:0] m_reg [6];
  logic [5:0]  m_flag;
  logic [2:0]  m_en;

  always #5 clk = ~clk;

  adc_flag_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .sample_i(sample),
    .rd_a_i(rd_a), .rd_a_ch_i(ch_a), .rd_a_data_o(da),
    .rd_b_i(rd_b), .rd_b_ch_i(ch_b), .rd_b_data_o(db),
    .ctrl_wr_i(wr), .ctrl_wdata_i(wdata), .gie_i(gie),
    .ctrl_o(ctrl), .irq_o(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = '0; m_en = '0;
      for (int c = 0; c < 6; c++) m_reg[c] = '0;
    end else begin
      for (int c = 0; c < 6; c++) begin
        if (load[c/2]) begin
          m_flag[c] = 1'b1;
          m_reg[c] = sample[16*c +: 16];
        end else if ((rd_a && ch_a == 3'(c)) || (rd_b && ch_b == 3'(c))) begin
          m_flag[c] = 1'b0;
        end
      end
      if (wr) m_en = wdata[8:6];
    end
  end

  function automatic logic [15:0] exp_data(input logic [2:0] ch);
    return (ch < 6) ? m_reg[ch] : 16'h0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    logic [2:0] ei;
    for (int p = 0; p < 3; p++)
      ei[p] = gie && m_en[p] && (m_flag[2*p] || m_flag[2*p+1]);
    chk("R2 R4 R5 R6 flags", {10'h0, ctrl[5:0]}, {10'h0, m_flag});
    chk("R8 control word", {ctrl[15:6], 6'h0}, {7'h0, m_en, 6'h0});
    chk("R7 irq", {13'h0, irq}, {13'h0, ei});
    chk("R3 R9 port A data", da, exp_data(ch_a));
    chk("R3 R9 port B data", db, exp_data(ch_b));
  endtask

  // check state left by the previous edge, then drive the next stimulus
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    load = '0; rd_a = 0; rd_b = 0; wr = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 6; c++) sample[16*c +: 16] = 16'hA000 + 16'(c * 16'h111);
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl, 16'h0);
    chk("R1 irq", {13'h0, irq}, 16'h0);
    chk("R1 data", da, 16'h0);
    rst_n = 1;
    step();
    // R2 pair 0 load, interrupts masked
    load = 3'b001; step(); idle();
    step();
    // R8 write all ones: only enables land
    wr = 1; wdata = 16'hFFFF; step(); idle();
    step();
    // R7 open global enable
    gie = 1; step();
    // R4 port A clears channel 0 only
    rd_a = 1; ch_a = 0; step(); idle(); step();
    // R5 port B clears channel 1
    rd_b = 1; ch_b = 1; step(); idle(); step();
    // R6 load pair 1 while reading channel 2
    load = 3'b010; rd_a = 1; ch_a = 2; sample[32 +: 16] = 16'h1234; step(); idle(); step();
    // R9 out of range index
    rd_a = 1; ch_a = 7; rd_b = 1; ch_b = 6; step(); idle(); step();
    // R5 both ports, different channels
    rd_a = 1; ch_a = 2; rd_b = 1; ch_b = 3; step(); idle(); step();
    // R8 disable pair 1 enable while flags set
    load = 3'b111; step(); idle();
    wr = 1; wdata = 16'h0140; step(); idle(); step();
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      load = 3'($urandom);
      for (int c = 0; c < 6; c++) sample[16*c +: 16] = 16'($urandom);
      rd_a = 1'($urandom); ch_a = 3'($urandom);
      rd_b = 1'($urandom); ch_b = 3'($urandom);
      wr = ($urandom % 8) == 0; wdata = 16'($urandom);
      gie = ($urandom % 4) != 0;
      step();
    end
    idle();
    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    #2;
    chk("R1 ctrl after reset", ctrl, 16'h0);
    chk("R1 irq after reset", {13'h0, irq}, 16'h0);
    chk("R1 data after reset", da, 16'h0);
    @(negedge clk); rst_n = 1;
    step(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule